// File: doc/BRIEF.md
# Truncated High-Half Multiplier with Column-Driven Correction

This block multiplies two unsigned n-bit operands and returns only the upper n bits of the product, rounded. It saves area by forming and summing only the partial products whose column weight lies in the upper n+k columns of the 2n-column matrix. The low n-k columns are never added. The k extra guard columns below the result keep the rounding error small.

The missing low columns are compensated by a correction term added into the kept sum. The term has three values, selected per operation. One partial-product column, the highest of the discarded columns, is watched. When all of its bits are one, the discarded mass is likely large and the correction is raised. When all of its bits are zero, the correction is lowered. Otherwise the nominal value is used. The corrected sum is rounded half-up to n bits and registered.

Top module: `tcm_mult`

## Requirements
- R1: The result port `prod_hi` is a register. It shows the result for the operands present at the previous rising clock edge and holds while the operands hold. A synchronous active-high reset clears it to 0.
- R2: A partial product `opa[i] & opb[j]` belongs to column i+j. Only columns N-K through 2N-1 are summed, each at weight 2^(i+j-(N-K)) in the kept sum. Lower columns reach the result only through the correction choice.
- R3: When all N-K partial products of column N-K-1 are 1, the correction is the nominal value plus one unit. A unit is one least significant bit of the kept sum, which has weight 2^(N-K).
- R4: When all partial products of column N-K-1 are 0, the correction is the nominal value minus one unit, floored at 0.
- R5: In every other case the nominal correction applies. It is round((1/4) * sum over c < N-K of (c+1)*2^c / 2^(N-K)), computed at elaboration; for N=8, K=2 it is 1 unit.
- R6: The corrected sum is rounded half-up by adding 2^(K-1) and dropping its K low bits. If the rounded value needs more than N bits, the result is all ones.
- R7: |prod_hi*2^N - opa*opb| never exceeds Dmax + (nominal+1)*2^(N-K) + 2^(N-1), where Dmax is the sum of all discarded column weights.
- R8: A zero operand gives a result of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| opa | input | N | Unsigned operand A |
| opb | input | N | Unsigned operand B |
| prod_hi | output | N | Rounded, corrected upper half of the product |

## Verification
The bench sweeps every operand pair of the 8-bit, k=2 configuration. It compares each result against a model that starts from the exact product and subtracts the discarded partial-product mass, so that any mis-weighted or misplaced kept column shows up as a value error. It also checks the absolute error against the R7 bound.

The column-probe corners are the all-ones and all-zero states of column N-K-1. If the raise and lower cases are swapped, or if the wrong diagonal is probed, the result is off by one in exactly those operand pairs. A rounding constant at the wrong bit, or truncation in place of rounding, shifts about half of all results by one. Separate checks cover the reset value, the result holding while operands hold, and a zero operand.

// File: rtl/tcm_pkg.sv
package tcm_pkg;

    localparam int unsigned DEF_N = 8;
    localparam int unsigned DEF_K = 2;

    // Correction choice driven by the probed discarded column
    typedef enum logic [1:0] {
        CORR_NOM = 2'd0,
        CORR_DEC = 2'd1,
        CORR_INC = 2'd2
    } corr_sel_e;

    typedef struct packed {
        logic full;
        logic empty;
    } col_state_t;

    // Expected discarded mass with each bit one with probability 1/4,
    // expressed in units of the kept-sum LSB and rounded to nearest.
    function automatic int unsigned nominal_units(int unsigned n, int unsigned k);
        longint unsigned mass;
        longint unsigned unit;
        mass = 0;
        unit = longint'(1) << (n - k);
        for (int unsigned c = 0; c < n - k; c++) begin
            mass += longint'(c + 1) << c;
        end
        return int'((mass + 2 * unit) / (4 * unit));
    endfunction

    function automatic int unsigned inc_units(int unsigned n, int unsigned k);
        return nominal_units(n, k) + 1;
    endfunction

    function automatic int unsigned dec_units(int unsigned n, int unsigned k);
        int unsigned nom;
        nom = nominal_units(n, k);
        return (nom == 0) ? 0 : nom - 1;
    endfunction

endpackage

// File: rtl/tcm_pp_array.sv
module tcm_pp_array
    import tcm_pkg::*;
#(
    parameter int unsigned N = DEF_N
) (
    input  logic [N-1:0]   opa,
    input  logic [N-1:0]   opb,
    output logic [N*N-1:0] pp
);

    // pp[i*N + j] = opa[i] & opb[j], column i+j
    for (genvar gi = 0; gi < N; gi++) begin : g_row
        for (genvar gj = 0; gj < N; gj++) begin : g_col
            assign pp[gi*N + gj] = opa[gi] & opb[gj];
        end
    end

endmodule

// File: rtl/tcm_col_probe.sv
module tcm_col_probe
    import tcm_pkg::*;
#(
    parameter int unsigned W = DEF_N - DEF_K
) (
    input  logic [W-1:0] col_bits,
    output col_state_t   state,
    output corr_sel_e    sel
);

    always_comb begin
        state.full  = &col_bits;
        state.empty = ~|col_bits;
        if (state.full) begin
            sel = CORR_INC;
        end else if (state.empty) begin
            sel = CORR_DEC;
        end else begin
            sel = CORR_NOM;
        end
    end

endmodule

// File: rtl/tcm_round_sum.sv
module tcm_round_sum
    import tcm_pkg::*;
#(
    parameter int unsigned N = DEF_N,
    parameter int unsigned K = DEF_K
) (
    input  logic [N*N-1:0] pp,
    input  corr_sel_e      sel,
    output logic [N-1:0]   result
);

    localparam int unsigned LOW   = N - K;
    localparam int unsigned ACC_W = N + K + 2;
    localparam int unsigned NOM_U = nominal_units(N, K);
    localparam int unsigned INC_U = inc_units(N, K);
    localparam int unsigned DEC_U = dec_units(N, K);
    localparam logic [ACC_W-1:0] RND_ONE = ACC_W'(1) << (K - 1);

    logic [ACC_W-1:0] kept_sum;
    logic [ACC_W-1:0] corr_v;
    logic [ACC_W-1:0] rnd_sum;
    logic [ACC_W-1:0] shifted;
    logic             overflow;

    // Weighted sum of the kept columns, LSB weight 2^LOW
    always_comb begin
        kept_sum = '0;
        for (int i = 0; i < int'(N); i++) begin
            for (int j = 0; j < int'(N); j++) begin
                if (i + j >= int'(LOW)) begin
                    kept_sum = kept_sum + (ACC_W'(pp[i*int'(N) + j]) << (i + j - int'(LOW)));
                end
            end
        end
    end

    always_comb begin
        unique case (sel)
            CORR_INC: corr_v = ACC_W'(INC_U);
            CORR_DEC: corr_v = ACC_W'(DEC_U);
            default:  corr_v = ACC_W'(NOM_U);
        endcase
    end

    assign rnd_sum  = kept_sum + corr_v + RND_ONE;
    assign shifted  = rnd_sum >> K;
    assign overflow = |shifted[ACC_W-1:N];
    assign result   = overflow ? '1 : shifted[N-1:0];

endmodule

// File: rtl/tcm_mult.sv
module tcm_mult
    import tcm_pkg::*;
#(
    parameter int unsigned N = DEF_N,
    parameter int unsigned K = DEF_K
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] opa,
    input  logic [N-1:0] opb,
    output logic [N-1:0] prod_hi
);

    localparam int unsigned LOW = N - K;

    logic [N*N-1:0] pp;
    logic [LOW-1:0] probe_bits;
    col_state_t     col_st;
    corr_sel_e      sel;
    logic [N-1:0]   result;

    tcm_pp_array #(.N(N)) u_pp (
        .opa (opa),
        .opb (opb),
        .pp  (pp)
    );

    // Diagonal of column LOW-1: opa[g] & opb[LOW-1-g]
    for (genvar g = 0; g < LOW; g++) begin : g_probe
        assign probe_bits[g] = pp[g*N + (LOW - 1 - g)];
    end

    tcm_col_probe #(.W(LOW)) u_probe (
        .col_bits (probe_bits),
        .state    (col_st),
        .sel      (sel)
    );

    tcm_round_sum #(.N(N), .K(K)) u_sum (
        .pp     (pp),
        .sel    (sel),
        .result (result)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            prod_hi <= '0;
        end else begin
            prod_hi <= result;
        end
    end

    // R3
    full_col_raises_chk: assert property (@(posedge clk) disable iff (rst)
        ((&opa) && (&opb)) |-> (sel == CORR_INC && col_st.full));

    // R4
    empty_col_lowers_chk: assert property (@(posedge clk) disable iff (rst)
        (opa == '0) |-> (sel == CORR_DEC && col_st.empty));

    // R8
    zero_operand_chk: assert property (@(posedge clk) disable iff (rst)
        ((opa == '0) || (opb == '0)) |=> (prod_hi == '0));

    // R1
    hold_result_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && opa == $past(opa) && opb == $past(opb)) |=> $stable(prod_hi));

endmodule

// File: tb/test_tcm_mult.sv
module test_tcm_mult;

    localparam int N   = 8;
    localparam int K   = 2;
    localparam int LOW = N - K;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] opa = '0;
    logic [N-1:0] opb = '0;
    logic [N-1:0] prod_hi;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    tcm_mult #(.N(N), .K(K)) i_tcm_mult (
        .clk     (clk),
        .rst     (rst),
        .opa     (opa),
        .opb     (opb),
        .prod_hi (prod_hi)
    );

    function automatic longint nom_units();
        longint mass = 0;
        for (int c = 0; c < LOW; c++) mass += longint'(c + 1) * (longint'(1) << c);
        return (mass + 2 * (longint'(1) << LOW)) / (4 * (longint'(1) << LOW));
    endfunction

    function automatic longint dmax();
        longint m = 0;
        for (int c = 0; c < LOW; c++) m += longint'(c + 1) * (longint'(1) << c);
        return m;
    endfunction

    // 0: mixed, 1: probed column all ones, 2: all zeros
    function automatic int col_kind(int x, int y);
        int cnt = 0;
        for (int i = 0; i < LOW; i++) cnt += ((x >> i) & 1) & ((y >> (LOW - 1 - i)) & 1);
        if (cnt == LOW) return 1;
        if (cnt == 0) return 2;
        return 0;
    endfunction

    function automatic longint model(int x, int y);
        longint prod = longint'(x) * longint'(y);
        longint disc = 0;
        longint corr;
        longint r;
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                if (i + j < LOW)
                    disc += longint'(((x >> i) & 1) & ((y >> j) & 1)) << (i + j);
        case (col_kind(x, y))
            1:       corr = nom_units() + 1;
            2:       corr = (nom_units() > 0) ? nom_units() - 1 : 0;
            default: corr = nom_units();
        endcase
        r = (((prod - disc) >> LOW) + corr + (longint'(1) << (K - 1))) >> K;
        if (r > (longint'(1) << N) - 1) r = (longint'(1) << N) - 1;
        return r;
    endfunction

    task automatic check(string tag, longint act, longint exp, int x, int y);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d", tag, x, y, act, exp);
        end
    endtask

    task automatic check_vector(int x, int y);
        string tag;
        longint err;
        longint bound;
        case (col_kind(x, y))
            1:       tag = "R3 R2 R6";
            2:       tag = "R4 R2 R6";
            default: tag = "R5 R2 R6";
        endcase
        check(tag, longint'(prod_hi), model(x, y), x, y);
        err = longint'(prod_hi) * (longint'(1) << N) - longint'(x) * longint'(y);
        if (err < 0) err = -err;
        bound = dmax() + (nom_units() + 1) * (longint'(1) << LOW) + (longint'(1) << (N - 1));
        checks++;
        if (err > bound) begin
            errors++;
            $display("FAIL R7 a=%0d b=%0d actual_err=%0d expected_max=%0d", x, y, err, bound);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d cycles expected=finish", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int px = 0;
        int py = 0;
        repeat (3) @(negedge clk);
        check("R1 reset", longint'(prod_hi), 0, 0, 0);
        rst = 1'b0;

        // Exhaustive sweep, one vector per cycle
        for (int v = 0; v <= (1 << (2 * N)); v++) begin
            @(negedge clk);
            if (v > 0) check_vector(px, py);
            if (v < (1 << (2 * N))) begin
                px = v >> N;
                py = v & ((1 << N) - 1);
                opa = N'(px);
                opb = N'(py);
            end
        end

        // Directed: all ones, probed column full
        opa = '1; opb = '1;
        @(negedge clk);
        check("R3 all-ones", longint'(prod_hi), model(255, 255), 255, 255);
        check("R3 literal", longint'(prod_hi), 253, 255, 255);

        // Hold: operands unchanged over several cycles
        repeat (3) begin
            @(negedge clk);
            check("R1 hold", longint'(prod_hi), 253, 255, 255);
        end

        // Zero operand
        opa = '0; opb = 8'd201;
        @(negedge clk);
        check("R8 zero-a", longint'(prod_hi), 0, 0, 201);
        opa = 8'd77; opb = '0;
        @(negedge clk);
        check("R8 zero-b", longint'(prod_hi), 0, 77, 0);

        // Reset in mid-run clears the register
        opa = 8'd200; opb = 8'd199;
        @(negedge clk);
        check("R6 mid", longint'(prod_hi), model(200, 199), 200, 199);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset-mid", longint'(prod_hi), 0, 200, 199);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after-reset", longint'(prod_hi), model(200, 199), 200, 199);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule